// File: doc/BRIEF.md
# Block-Counted Data Transfer Sequencer

This block steers the movement of 32-bit words between a host-side word FIFO and a card-side data port, and counts the transfer in bytes grouped into power-of-two blocks. Software programs three values before raising the enable: a total byte length, a timeout reload count in card clock periods, and a block size exponent together with a direction flag. When enable is raised, the sequencer latches these values. It then moves one word per cycle whenever the side that supplies the word and the side that takes it are both ready, and it keeps a count of the words still to move.

In the write direction (host to card) a word leaves the FIFO when the card asks for one. After each block, and after the last word, the sequencer waits until the card drops its busy flag. In the read direction (card to host) a word offered by the card enters the FIFO when the FIFO has room. One-cycle event pulses mark the end of every full block, the end of the whole transfer, a timeout, a transmit underrun and a receive overrun. Any error stops the transfer. After completion or an error the sequencer holds until enable is cleared, and clearing enable at any time returns it to idle.

Top module: `blkxfer_seq`

## Requirements
- R1: With enable high in idle, the sequencer latches length, direction, exponent and timeout; in the next cycle words_left equals ceil(length/4). A length of 0 gives a data-end pulse in that next cycle and no word moves.
- R2: Write direction (ctl_dir=0): in an active transfer cycle with card_rdy high and fifo_empty low, fifo_pop and card_wvld are both high and card_wdata equals fifo_rdata in the same cycle; otherwise both are low.
- R3: Read direction (ctl_dir=1): in an active transfer cycle with card_vld high and fifo_full low, fifo_push and card_rack are both high and fifo_wdata equals card_rdata in the same cycle.
- R4: words_left falls by exactly one in the cycle after each moved word and holds otherwise.
- R5: The block size is 2^ctl_exp bytes, with exponents below 2 treated as 2 and above 11 treated as 11. ev_blk_end pulses one cycle after the word that completes each full block; a short final block gives no pulse.
- R6: ev_data_end pulses one cycle after the last word moves (read), or one cycle after card_busy is seen low following the last word (write). No further word moves until enable is cleared and raised again.
- R7: In the write direction, after each full block and after the last word the sequencer moves no word until a cycle in which card_busy is low.
- R8: The timeout counter reloads at start, when a block or the transfer's last word completes, and when a busy wait releases. It counts the transfer cycles without a move and the busy-wait cycles with card_busy high. On the max(T,1)-th such cycle since the last reload, ev_timeout pulses one cycle later and the transfer stops.
- R9: A write cycle with card_rdy high and fifo_empty high gives an ev_underrun pulse one cycle later and stops the transfer. A FIFO error takes priority over a timeout in the same cycle.
- R10: A read cycle with card_vld high and fifo_full high gives an ev_overrun pulse one cycle later, moves no word and stops the transfer.
- R11: While ctl_en is low no word moves, and the sequencer is in idle at the next edge.
- R12: During and right after reset, no strobe or event is high and words_left is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Transfer enable; clearing it aborts |
| ctl_dir | input | 1 | 1 = card to host (read), 0 = host to card |
| ctl_exp | input | 4 | Block size as log2 of bytes |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| tmo_count | input | TMR_W | Timeout reload in card clock periods |
| fifo_empty | input | 1 | Host FIFO has no word |
| fifo_full | input | 1 | Host FIFO has no room |
| fifo_rdata | input | DW | Head word of host FIFO |
| fifo_pop | output | 1 | Take head word from FIFO |
| fifo_push | output | 1 | Write fifo_wdata into FIFO |
| fifo_wdata | output | DW | Word written into FIFO |
| card_rdy | input | 1 | Card side wants a word (write) |
| card_wvld | output | 1 | Word on card_wdata is handed over |
| card_wdata | output | DW | Word sent to card side |
| card_vld | input | 1 | Card side offers a word (read) |
| card_rdata | input | DW | Word from card side |
| card_rack | output | 1 | Offered card word is accepted |
| card_busy | input | 1 | Card is busy after a written block |
| words_left | output | LEN_W-1 | 32-bit words still to move |
| ev_blk_end | output | 1 | Full block completed pulse |
| ev_data_end | output | 1 | Transfer completed pulse |
| ev_timeout | output | 1 | Data timeout pulse |
| ev_underrun | output | 1 | Transmit underrun pulse |
| ev_overrun | output | 1 | Receive overrun pulse |

## Verification
Two functions land on the same clock edge in two places. On a read whose length is a whole number of blocks, the last word ends both a block and the transfer, so ev_blk_end and ev_data_end must pulse together in one cycle. Random FIFO empty/full stimulus also produces cycles that are idle for the timer and erroneous at once, and there the error event must appear while the timeout stays silent. Both cases come from directed length and exponent choices mixed with random handshakes. A behavioural model advanced every clock judges every strobe, event and the word count on each cycle.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam logic [3:0] EXP_MIN = 4'd2;
    localparam logic [3:0] EXP_MAX = 4'd11;
    localparam int unsigned BLK_CW = int'(EXP_MAX) - int'(EXP_MIN) + 1;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_XFER = 2'd1,
        DS_WAIT = 2'd2,
        DS_HALT = 2'd3
    } dps_state_e;

    typedef struct packed {
        logic blk_end;
        logic data_end;
        logic timeout;
        logic underrun;
        logic overrun;
    } dps_evt_t;

    function automatic logic [3:0] clamp_exp(input logic [3:0] e);
        if (e < EXP_MIN) return EXP_MIN;
        if (e > EXP_MAX) return EXP_MAX;
        return e;
    endfunction

    function automatic int unsigned len_bits(input bit wide);
        return wide ? 24 : 16;
    endfunction

endpackage

// File: rtl/dps_timer.sv
module dps_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] start_val,
    input  logic          reload,
    input  logic          count,
    output logic          at_limit
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            val_q <= '0;
        end else if (start) begin
            val_q <= start_val;
            cnt_q <= start_val;
        end else if (reload) begin
            cnt_q <= val_q;
        end else if (count && (cnt_q != '0)) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign at_limit = (cnt_q <= TW'(1));

endmodule

// File: rtl/dps_wordcnt.sv
module dps_wordcnt
    import dps_pkg::*;
#(
    parameter int unsigned WW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [WW-1:0] load_words,
    input  logic [3:0]    load_exp,
    input  logic          step,
    output logic [WW-1:0] words_left,
    output logic          last_word,
    output logic          rem_zero,
    output logic          blk_last
);
    logic [WW-1:0]     rem_q;
    logic [BLK_CW-1:0] blk_q;
    logic [BLK_CW-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            blk_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            rem_q <= load_words;
            blk_q <= '0;
            lim_q <= (BLK_CW'(1) << (load_exp - EXP_MIN)) - BLK_CW'(1);
        end else if (step) begin
            rem_q <= rem_q - WW'(1);
            blk_q <= (blk_q == lim_q) ? '0 : blk_q + BLK_CW'(1);
        end
    end

    assign words_left = rem_q;
    assign last_word  = (rem_q == WW'(1));
    assign rem_zero   = (rem_q == '0);
    assign blk_last   = (blk_q == lim_q);

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
    import dps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     dir_in,
    input  logic     has_words,
    input  logic     fifo_empty,
    input  logic     fifo_full,
    input  logic     card_rdy,
    input  logic     card_vld,
    input  logic     card_busy,
    input  logic     last_word,
    input  logic     rem_zero,
    input  logic     blk_last,
    input  logic     tmr_at_limit,
    output logic     start,
    output logic     step,
    output logic     pop,
    output logic     push,
    output logic     tmr_reload,
    output logic     tmr_count,
    output dps_evt_t evt
);
    dps_state_e st_q, st_d;
    logic       dir_q;
    dps_evt_t   evt_d;

    logic in_x, in_w, under, over, blk_done, fin, release_w, tmo_hit;

    always_comb begin
        start     = en && (st_q == DS_IDLE);
        in_x      = en && (st_q == DS_XFER);
        in_w      = en && (st_q == DS_WAIT);
        pop       = in_x && !dir_q && card_rdy && !fifo_empty;
        push      = in_x && dir_q && card_vld && !fifo_full;
        under     = in_x && !dir_q && card_rdy && fifo_empty;
        over      = in_x && dir_q && card_vld && fifo_full;
        step      = pop || push;
        blk_done  = step && blk_last;
        fin       = step && last_word;
        release_w = in_w && !card_busy;
        tmr_count = (in_x && !step) || (in_w && card_busy);
        tmo_hit   = tmr_count && tmr_at_limit && !under && !over;
        tmr_reload = blk_done || fin || release_w;
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = DS_IDLE;
        end else begin
            unique case (st_q)
                DS_IDLE: st_d = has_words ? DS_XFER : DS_HALT;
                DS_XFER: begin
                    if (under || over || tmo_hit)       st_d = DS_HALT;
                    else if ((blk_done || fin) && !dir_q) st_d = DS_WAIT;
                    else if (fin)                       st_d = DS_HALT;
                end
                DS_WAIT: begin
                    if (release_w)    st_d = rem_zero ? DS_HALT : DS_XFER;
                    else if (tmo_hit) st_d = DS_HALT;
                end
                default: st_d = DS_HALT;
            endcase
        end
    end

    always_comb begin
        evt_d          = '0;
        evt_d.blk_end  = blk_done;
        evt_d.data_end = (start && !has_words) || (fin && dir_q) ||
                         (release_w && rem_zero);
        evt_d.timeout  = tmo_hit;
        evt_d.underrun = under;
        evt_d.overrun  = over;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DS_IDLE;
            dir_q <= 1'b0;
            evt   <= '0;
        end else begin
            st_q <= st_d;
            evt  <= evt_d;
            if (start) dir_q <= dir_in;
        end
    end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import dps_pkg::*;
#(
    parameter bit          WIDE_LEN = 1'b0,
    parameter int unsigned TMR_W    = 16,
    parameter int unsigned DW       = 32,
    localparam int unsigned LEN_W   = len_bits(WIDE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_en,
    input  logic             ctl_dir,
    input  logic [3:0]       ctl_exp,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [TMR_W-1:0] tmo_count,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    input  logic [DW-1:0]    fifo_rdata,
    output logic             fifo_pop,
    output logic             fifo_push,
    output logic [DW-1:0]    fifo_wdata,
    input  logic             card_rdy,
    output logic             card_wvld,
    output logic [DW-1:0]    card_wdata,
    input  logic             card_vld,
    input  logic [DW-1:0]    card_rdata,
    output logic             card_rack,
    input  logic             card_busy,
    output logic [LEN_W-2:0] words_left,
    output logic             ev_blk_end,
    output logic             ev_data_end,
    output logic             ev_timeout,
    output logic             ev_underrun,
    output logic             ev_overrun
);
    localparam int unsigned WW = LEN_W - 1;

    logic [WW-1:0] words_req;
    logic          has_words;
    logic          start, step, tmr_reload, tmr_count, tmr_at_limit;
    logic          last_word, rem_zero, blk_last;
    dps_evt_t      evt;

    assign words_req = {1'b0, xfer_len[LEN_W-1:2]} + WW'(|xfer_len[1:0]);
    assign has_words = |xfer_len;

    dps_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .en           (ctl_en),
        .dir_in       (ctl_dir),
        .has_words    (has_words),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .card_rdy     (card_rdy),
        .card_vld     (card_vld),
        .card_busy    (card_busy),
        .last_word    (last_word),
        .rem_zero     (rem_zero),
        .blk_last     (blk_last),
        .tmr_at_limit (tmr_at_limit),
        .start        (start),
        .step         (step),
        .pop          (fifo_pop),
        .push         (fifo_push),
        .tmr_reload   (tmr_reload),
        .tmr_count    (tmr_count),
        .evt          (evt)
    );

    dps_wordcnt #(.WW(WW)) u_wcnt (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .load_words (words_req),
        .load_exp   (clamp_exp(ctl_exp)),
        .step       (step),
        .words_left (words_left),
        .last_word  (last_word),
        .rem_zero   (rem_zero),
        .blk_last   (blk_last)
    );

    dps_timer #(.TW(TMR_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_val (tmo_count),
        .reload    (tmr_reload),
        .count     (tmr_count),
        .at_limit  (tmr_at_limit)
    );

    assign card_wvld  = fifo_pop;
    assign card_wdata = fifo_rdata;
    assign card_rack  = fifo_push;
    assign fifo_wdata = card_rdata;

    assign ev_blk_end  = evt.blk_end;
    assign ev_data_end = evt.data_end;
    assign ev_timeout  = evt.timeout;
    assign ev_underrun = evt.underrun;
    assign ev_overrun  = evt.overrun;

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int unsigned WL_W = 15
) (
    input logic            clk,
    input logic            rst,
    input logic            ctl_en,
    input logic            fifo_pop,
    input logic            fifo_push,
    input logic [WL_W-1:0] words_left,
    input logic            ev_blk_end,
    input logic            ev_data_end,
    input logic            ev_timeout,
    input logic            ev_underrun,
    input logic            ev_overrun
);
    assert_move_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(fifo_pop && fifo_push));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop || fifo_push) |=> (words_left == $past(words_left) - WL_W'(1)));

    assert_blk_after_move_R5: assert property (@(posedge clk) disable iff (rst)
        ev_blk_end |-> $past(fifo_pop || fifo_push));

    assert_quiet_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        ev_data_end |-> (!fifo_pop && !fifo_push));

    assert_timeout_no_move_R8: assert property (@(posedge clk) disable iff (rst)
        ev_timeout |-> !$past(fifo_pop || fifo_push));

    assert_single_error_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_timeout, ev_underrun, ev_overrun}));

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> (!fifo_pop && !fifo_push));

endmodule

bind blkxfer_seq dps_checker #(.WL_W(LEN_W - 1)) u_dps_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_en      (ctl_en),
    .fifo_pop    (fifo_pop),
    .fifo_push   (fifo_push),
    .words_left  (words_left),
    .ev_blk_end  (ev_blk_end),
    .ev_data_end (ev_data_end),
    .ev_timeout  (ev_timeout),
    .ev_underrun (ev_underrun),
    .ev_overrun  (ev_overrun)
);

// File: tb/tb_blkxfer_seq.sv
`timescale 1ns/1ps
module tb_blkxfer_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_en, ctl_dir;
    logic [3:0]  ctl_exp;
    logic [15:0] xfer_len;
    logic [15:0] tmo_count;
    logic        fifo_empty, fifo_full, card_rdy, card_vld, card_busy;
    logic [31:0] fifo_rdata, card_rdata;
    logic        fifo_pop, fifo_push, card_wvld, card_rack;
    logic [31:0] fifo_wdata, card_wdata;
    logic [14:0] words_left;
    logic        ev_blk_end, ev_data_end, ev_timeout, ev_underrun, ev_overrun;

    always #2 clk = ~clk;

    blkxfer_seq dut (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_dir(ctl_dir), .ctl_exp(ctl_exp),
        .xfer_len(xfer_len), .tmo_count(tmo_count),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .card_rdy(card_rdy), .card_wvld(card_wvld), .card_wdata(card_wdata),
        .card_vld(card_vld), .card_rdata(card_rdata), .card_rack(card_rack),
        .card_busy(card_busy), .words_left(words_left),
        .ev_blk_end(ev_blk_end), .ev_data_end(ev_data_end), .ev_timeout(ev_timeout),
        .ev_underrun(ev_underrun), .ev_overrun(ev_overrun)
    );

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int ms = 0;          // 0 idle, 1 moving, 2 busy wait, 3 halted
    int mrem = 0, mblk = 0, mtmr = 0, mtmo = 0, mexp = 2;
    bit mdir = 0;
    bit me_blk = 0, me_end = 0, me_to = 0, me_un = 0, me_ov = 0;
    bit m_started = 0;
    bit in_rst = 0;

    int p_rdy, p_empty, p_vld, p_full, p_busy;

    task automatic chk(input string tag, input string nm, input longint act, input longint expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, nm, act, expv, $time);
        end
    endtask

    task automatic compare();
        bit en, e_pop, e_push;
        string tp, tq, tw;
        en     = ctl_en;
        e_pop  = en && ms == 1 && !mdir && card_rdy && !fifo_empty;
        e_push = en && ms == 1 && mdir && card_vld && !fifo_full;
        tp = in_rst ? "R12" : (!en ? "R11" : (ms == 2 ? "R7" : "R2"));
        tq = in_rst ? "R12" : (!en ? "R11" : "R3");
        tw = in_rst ? "R12" : (m_started ? "R1" : "R4");
        chk(tp, "fifo_pop", fifo_pop, e_pop);
        chk(tp, "card_wvld", card_wvld, e_pop);
        chk(tq, "fifo_push", fifo_push, e_push);
        chk(tq, "card_rack", card_rack, e_push);
        if (e_pop)  chk("R2", "card_wdata", card_wdata, fifo_rdata);
        if (e_push) chk("R3", "fifo_wdata", fifo_wdata, card_rdata);
        chk(tw, "words_left", words_left, mrem);
        chk(in_rst ? "R12" : "R5",  "ev_blk_end",  ev_blk_end,  me_blk);
        chk(in_rst ? "R12" : "R6",  "ev_data_end", ev_data_end, me_end);
        chk(in_rst ? "R12" : "R8",  "ev_timeout",  ev_timeout,  me_to);
        chk(in_rst ? "R12" : "R9",  "ev_underrun", ev_underrun, me_un);
        chk(in_rst ? "R12" : "R10", "ev_overrun",  ev_overrun,  me_ov);
    endtask

    task automatic tmr_tick();
        if (mtmr <= 1) begin me_to = 1; ms = 3; end
        else mtmr--;
    endtask

    task automatic model_step();
        bit en, mv, un, ov, bdone, fin;
        me_blk = 0; me_end = 0; me_to = 0; me_un = 0; me_ov = 0;
        m_started = 0;
        if (rst) begin
            ms = 0; mrem = 0; mblk = 0; mtmr = 0; mtmo = 0; mexp = 2; mdir = 0;
            return;
        end
        en = ctl_en;
        if (!en) begin ms = 0; return; end
        case (ms)
            0: begin
                mdir = ctl_dir;
                mexp = (ctl_exp < 2) ? 2 : ((ctl_exp > 11) ? 11 : int'(ctl_exp));
                mtmo = tmo_count; mtmr = tmo_count;
                mrem = (int'(xfer_len) + 3) / 4;
                mblk = 0;
                m_started = 1;
                if (mrem == 0) begin me_end = 1; ms = 3; end
                else ms = 1;
            end
            1: begin
                un = !mdir && card_rdy && fifo_empty;
                ov = mdir && card_vld && fifo_full;
                mv = (!mdir && card_rdy && !fifo_empty) || (mdir && card_vld && !fifo_full);
                if (un) begin me_un = 1; ms = 3; end
                else if (ov) begin me_ov = 1; ms = 3; end
                else if (mv) begin
                    mrem--; mblk++;
                    bdone = (mblk == (1 << (mexp - 2)));
                    fin = (mrem == 0);
                    if (bdone) begin mblk = 0; me_blk = 1; end
                    if (bdone || fin) mtmr = mtmo;
                    if (!mdir && (bdone || fin)) ms = 2;
                    else if (fin) begin me_end = 1; ms = 3; end
                end else tmr_tick();
            end
            2: begin
                if (!card_busy) begin
                    mtmr = mtmo;
                    if (mrem == 0) begin me_end = 1; ms = 3; end
                    else ms = 1;
                end else tmr_tick();
            end
            default: ;
        endcase
    endtask

    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        card_rdy   = ($urandom_range(99) < p_rdy);
        fifo_empty = ($urandom_range(99) < p_empty);
        card_vld   = ($urandom_range(99) < p_vld);
        fifo_full  = ($urandom_range(99) < p_full);
        card_busy  = ($urandom_range(99) < p_busy);
        fifo_rdata = $urandom;
        card_rdata = $urandom;
    endtask

    task automatic scen(input bit dir, input logic [3:0] ex, input int len, input int tmo,
                        input int ncyc, input int prdy, input int pemp, input int pvld,
                        input int pful, input int pbsy);
        p_rdy = prdy; p_empty = pemp; p_vld = pvld; p_full = pful; p_busy = pbsy;
        ctl_dir = dir; ctl_exp = ex; xfer_len = 16'(len); tmo_count = 16'(tmo);
        for (int c = 0; c < ncyc; c++) begin
            ctl_en = 1'b1;
            rand_inputs();
            tick();
        end
        for (int c = 0; c < 3; c++) begin
            ctl_en = 1'b0;
            rand_inputs();
            tick();
        end
    endtask

    initial begin
        rst = 1'b1; ctl_en = 0; ctl_dir = 0; ctl_exp = 0; xfer_len = 0; tmo_count = 0;
        fifo_empty = 1; fifo_full = 0; card_rdy = 0; card_vld = 0; card_busy = 0;
        fifo_rdata = 0; card_rdata = 0;
        p_rdy = 0; p_empty = 0; p_vld = 0; p_full = 0; p_busy = 0;
        @(posedge clk);
        @(negedge clk);
        in_rst = 1;
        for (int c = 0; c < 3; c++) tick();   // R12 reset state
        in_rst = 0;
        rst = 1'b0;
        // R5 R6: read, whole blocks, block end and data end together
        scen(1, 4'd4, 64, 20, 60, 0, 0, 80, 0, 0);
        // R1 R5: read with short final block
        scen(1, 4'd3, 18, 20, 40, 0, 0, 70, 0, 0);
        // R2 R7: write with busy waits
        scen(0, 4'd3, 32, 60, 140, 70, 0, 0, 0, 40);
        // R7: write, short final block
        scen(0, 4'd3, 12, 60, 60, 80, 0, 0, 0, 30);
        // R9: underrun
        scen(0, 4'd5, 200, 60, 80, 80, 25, 0, 0, 20);
        // R10: overrun
        scen(1, 4'd5, 200, 60, 80, 0, 0, 80, 20, 0);
        // R8: read timeout
        scen(1, 4'd3, 40, 5, 20, 0, 0, 0, 0, 0);
        // R8: zero reload
        scen(1, 4'd3, 40, 0, 8, 0, 0, 0, 0, 0);
        // R8: busy wait timeout
        scen(0, 4'd2, 8, 4, 20, 100, 0, 0, 0, 100);
        // R1: zero length
        scen(1, 4'd3, 0, 20, 10, 0, 0, 90, 0, 0);
        // R11: abort mid transfer
        scen(1, 4'd4, 400, 30, 15, 0, 0, 60, 0, 0);
        // R5: exponent clamps
        scen(1, 4'd0, 20, 30, 30, 0, 0, 70, 0, 0);
        scen(1, 4'd15, 40, 30, 40, 0, 0, 70, 0, 0);
        scen(0, 4'd1, 16, 30, 60, 70, 0, 0, 0, 20);
        // mixed random with error and timeout pressure
        scen(0, 4'd3, 100, 3, 120, 50, 15, 0, 0, 50);
        scen(1, 4'd2, 100, 3, 120, 0, 0, 50, 10, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #700000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule